// File: doc/BRIEF.md
# Delay-Sweep Edge Measurement Controller

This controller measures an unknown delay in units of one delay step. Around it sit two external programmable delay paths and a sampling flip-flop. A single launch edge enters both paths. The reference path is held at its minimum setting and drives the device under measurement. The output of that device feeds the D input of a flip-flop, and the flip-flop is clocked by the programmable path. The controller sets the programmable path's code, fires launch strobes and reads back the captured bit. A captured high means the programmed delay is too long, so the code must come down. A captured low means the delay is too short, so the code must go up.

The search is a binary approximation from the top code bit down to the bottom bit. For each candidate code the controller runs a fixed number of trials and takes a majority vote. If the captured bit keeps changing between trials at one code, the controller takes that code as the answer and stops at once. If the search ends at code 0, one more round runs at code 0, and an underflow flag is set only when every trial in that round captures high. The result comes back with a one-cycle done pulse and a valid flag. The valid flag stays set until the next measurement is accepted.

Top module: `delay_sweep_meter`

## Requirements
- R1: While reset is high and after it is released, `done_o`, `result_valid_o`, `underflow_o` and `launch_o` are 0, and `result_o` and `code_o` are all zeros.
- R2: An accepted start begins a binary search on a CODE_W-bit code (10 bits by default, codes 0 to 1023). The first trial code has only the top bit set (512). After a round, the bit under test is cleared if the vote says high and kept if it says low. The next lower bit is then set for the following round. With no dithering, the result is the largest tested code that voted low.
- R3: Each trial raises `launch_o` for exactly one cycle. Call the launch cycle cycle 0. `sample_i` is captured at the clock edge that ends cycle S after it, where S is the value of `settle_i` when the trial is issued.
- R4: Every candidate code gets TRIALS trials (8 by default). The round votes high when the number of high captures is more than half of TRIALS. A minority of wrong captures does not change the decision.
- R5: A round in which both the high captures and the low captures are at least DITHER_MIN (2 by default) counts as dithering. The measurement then ends at once with the current code as its result, and `underflow_o` is 0.
- R6: If the search would end at code 0 without dithering, one extra round runs at code 0. The result is 0, and `underflow_o` is 1 only if all TRIALS captures in that round are high.
- R7: `done_o` is high for one cycle. In that cycle `result_o` and `underflow_o` hold the outcome and `result_valid_o` is 1. `result_valid_o` and `underflow_o` stay unchanged until the next accepted start, which clears them on the following cycle.
- R8: A start request while a measurement is running is ignored. The running search goes on unchanged, produces exactly one done pulse and issues its normal number of launches.
- R9: A measurement issues exactly TRIALS launches per round. It runs one round per code bit, plus the code-0 round of R6 when that round applies, and it stops early on dithering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new measurement (accepted only when idle) |
| settle_i | input | SETTLE_W | Cycles to wait after the launch cycle before capturing `sample_i` |
| sample_i | input | 1 | Bit captured by the external sampling flip-flop |
| launch_o | output | 1 | One-cycle launch strobe into both delay paths |
| code_o | output | CODE_W | Delay code for the programmable path |
| done_o | output | 1 | One-cycle end-of-measurement pulse |
| result_o | output | CODE_W | Measured delay code |
| result_valid_o | output | 1 | `result_o` holds a finished measurement |
| underflow_o | output | 1 | Every trial at code 0 captured high |

## Verification
On every cycle, the assertions check that each launch is a single-cycle strobe and that a capture only arrives while the controller waits for one. They also check that the vote count never passes the trial count, that done never lasts two cycles, and that underflow is only reported with a zero result. The correctness of the measured code, the majority vote against a noisy flip-flop, early stopping on dither, and the underflow rule all depend on a model of the delay paths that reacts to `code_o`. Only the bench scenarios can show these, along with the number of launches per run and the ignoring of a start while busy.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_FIRE  = 2'd1,
    C_WAIT  = 2'd2,
    C_CHECK = 2'd3
  } ctrl_st_e;

  typedef enum logic {
    T_IDLE = 1'b0,
    T_WAIT = 1'b1
  } trial_st_e;
endpackage

// File: rtl/dsm_trial.sv
// One trial: a single-cycle launch, a settle wait, then capture of the sampled bit.
module dsm_trial
  import dsm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                sample_i,
  output logic                launch_o,
  output logic                vld_o,
  output logic                bit_o
);
  trial_st_e           st;
  logic [SETTLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      cnt      <= '0;
      launch_o <= 1'b0;
      vld_o    <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      launch_o <= 1'b0;
      vld_o    <= 1'b0;
      case (st)
        T_IDLE: begin
          if (go_i) begin
            launch_o <= 1'b1;
            cnt      <= settle_i;
            st       <= T_WAIT;
          end
        end
        T_WAIT: begin
          if (cnt == '0) begin
            vld_o <= 1'b1;
            bit_o <= sample_i;
            st    <= T_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R3: the launch strobe never lasts longer than one cycle
  p_launch_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> !launch_o);
endmodule

// File: rtl/dsm_vote.sv
// Tallies the captures of one round and gives the majority, dither and all-high flags.
module dsm_vote #(
  parameter int TRIALS     = 8,
  parameter int DITHER_MIN = 2,
  localparam int CNT_W     = $clog2(TRIALS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic hit_i,
  input  logic bit_i,
  output logic full_o,
  output logic maj_high_o,
  output logic dither_o,
  output logic all_high_o
);
  logic [CNT_W-1:0] n_done, n_high, n_low;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      n_done <= '0;
      n_high <= '0;
    end else if (hit_i) begin
      n_done <= n_done + 1'b1;
      n_high <= n_high + CNT_W'(bit_i);
    end
  end

  always_comb begin
    n_low      = n_done - n_high;
    full_o     = (n_done == CNT_W'(TRIALS));
    maj_high_o = ({1'b0, n_high} << 1) > (CNT_W + 1)'(TRIALS);
    dither_o   = (n_high >= CNT_W'(DITHER_MIN)) && (n_low >= CNT_W'(DITHER_MIN));
    all_high_o = (n_high == CNT_W'(TRIALS));
  end

  // R4: a round never counts more trials than configured
  p_vote_bound_r4: assert property (@(posedge clk) disable iff (rst)
    n_done <= CNT_W'(TRIALS));
endmodule

// File: rtl/dsm_ctrl.sv
// Binary-search sequencer: picks the code, issues trials, applies the vote.
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int CODE_W = 10,
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              vld_i,
  input  logic              full_i,
  input  logic              maj_high_i,
  input  logic              dither_i,
  input  logic              all_high_i,
  output logic              go_o,
  output logic              clr_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] result_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              uf_o
);
  ctrl_st_e          st;
  logic [IDX_W-1:0]  idx;
  logic              verify;
  logic [CODE_W-1:0] cur_bit, next_bit, kept;

  always_comb begin
    go_o     = (st == C_FIRE);
    clr_o    = (st == C_IDLE) || ((st == C_CHECK) && full_i);
    cur_bit  = {{(CODE_W-1){1'b0}}, 1'b1} << idx;
    next_bit = cur_bit >> 1;
    kept     = maj_high_i ? (code_o & ~cur_bit) : code_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= C_IDLE;
      idx      <= '0;
      verify   <= 1'b0;
      code_o   <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
      uf_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        C_IDLE: begin
          if (start_i) begin
            code_o  <= {1'b1, {(CODE_W-1){1'b0}}};
            idx     <= IDX_W'(CODE_W - 1);
            verify  <= 1'b0;
            valid_o <= 1'b0;
            uf_o    <= 1'b0;
            st      <= C_FIRE;
          end
        end
        C_FIRE: st <= C_WAIT;
        C_WAIT: if (vld_i) st <= C_CHECK;
        C_CHECK: begin
          if (!full_i) begin
            st <= C_FIRE;
          end else if (dither_i) begin
            result_o <= code_o;
            uf_o     <= 1'b0;
            valid_o  <= 1'b1;
            done_o   <= 1'b1;
            st       <= C_IDLE;
          end else if (verify) begin
            result_o <= '0;
            uf_o     <= all_high_i;
            valid_o  <= 1'b1;
            done_o   <= 1'b1;
            st       <= C_IDLE;
          end else if (idx == '0) begin
            if (kept == '0) begin
              code_o <= '0;
              verify <= 1'b1;
              st     <= C_FIRE;
            end else begin
              result_o <= kept;
              uf_o     <= 1'b0;
              valid_o  <= 1'b1;
              done_o   <= 1'b1;
              st       <= C_IDLE;
            end
          end else begin
            code_o <= kept | next_bit;
            idx    <= idx - 1'b1;
            st     <= C_FIRE;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R3: a capture from the trial unit only arrives while a trial is awaited
  p_smp_in_wait_r3: assert property (@(posedge clk) disable iff (rst)
    vld_i |-> (st == C_WAIT));
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R6: underflow is only ever reported with a zero result
  p_uf_zero_r6: assert property (@(posedge clk) disable iff (rst)
    uf_o |-> (result_o == '0));
endmodule

// File: rtl/delay_sweep_meter.sv
module delay_sweep_meter
  import dsm_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int TRIALS     = 8,
  parameter int DITHER_MIN = 2,
  parameter int SETTLE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                sample_i,
  output logic                launch_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                done_o,
  output logic [CODE_W-1:0]   result_o,
  output logic                result_valid_o,
  output logic                underflow_o
);
  logic go, clr, t_vld, t_bit;
  logic full, maj_high, dither, all_high;

  dsm_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .vld_i      (t_vld),
    .full_i     (full),
    .maj_high_i (maj_high),
    .dither_i   (dither),
    .all_high_i (all_high),
    .go_o       (go),
    .clr_o      (clr),
    .code_o     (code_o),
    .result_o   (result_o),
    .valid_o    (result_valid_o),
    .done_o     (done_o),
    .uf_o       (underflow_o)
  );

  dsm_trial #(.SETTLE_W(SETTLE_W)) u_trial (
    .clk      (clk),
    .rst      (rst),
    .go_i     (go),
    .settle_i (settle_i),
    .sample_i (sample_i),
    .launch_o (launch_o),
    .vld_o    (t_vld),
    .bit_o    (t_bit)
  );

  dsm_vote #(.TRIALS(TRIALS), .DITHER_MIN(DITHER_MIN)) u_vote (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .hit_i      (t_vld),
    .bit_i      (t_bit),
    .full_o     (full),
    .maj_high_o (maj_high),
    .dither_o   (dither),
    .all_high_o (all_high)
  );
endmodule

// File: tb/delay_sweep_meter_bench.sv
module delay_sweep_meter_bench;
  localparam int CODE_W = 10;
  localparam int TRIALS = 8;
  localparam int SW     = 8;

  typedef struct packed {
    logic [1:0] mode;   // 0: dither at d, 1: clean step at d, 2: step with one flip per round
    logic [9:0] d;
    logic [9:0] res;
    logic       uf;
    logic [3:0] rounds;
    logic [3:0] settle;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 10'd0,    10'd0,    1'b0, 4'd11, 4'd1},
    '{2'd0, 10'd1023, 10'd1023, 1'b0, 4'd10, 4'd2},
    '{2'd0, 10'd1,    10'd1,    1'b0, 4'd10, 4'd3},
    '{2'd0, 10'd512,  10'd512,  1'b0, 4'd1,  4'd4},
    '{2'd0, 10'd341,  10'd341,  1'b0, 4'd10, 4'd5},
    '{2'd0, 10'd682,  10'd682,  1'b0, 4'd9,  4'd2},
    '{2'd1, 10'd0,    10'd0,    1'b1, 4'd11, 4'd1},
    '{2'd1, 10'd1,    10'd0,    1'b0, 4'd11, 4'd3},
    '{2'd1, 10'd700,  10'd699,  1'b0, 4'd10, 4'd4},
    '{2'd1, 10'd1023, 10'd1022, 1'b0, 4'd10, 4'd2},
    '{2'd2, 10'd0,    10'd0,    1'b0, 4'd11, 4'd3},
    '{2'd2, 10'd300,  10'd299,  1'b0, 4'd10, 4'd5}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [SW-1:0]     settle_i = 8'd3;
  logic              sample_i;
  logic              launch_o, done_o, result_valid_o, underflow_o;
  logic [CODE_W-1:0] code_o, result_o;

  int checks = 0;
  int bad    = 0;
  longint cyc = 0;

  // delay-path model
  logic [1:0] mode = 2'd1;
  logic [9:0] dval = 10'd0;
  logic       tog;
  int         lc;
  int         age;
  logic       ideal, flip;

  always #4 clk = ~clk;

  delay_sweep_meter u_delay_sweep_meter (
    .clk(clk), .rst(rst), .start_i(start_i), .settle_i(settle_i),
    .sample_i(sample_i), .launch_o(launch_o), .code_o(code_o),
    .done_o(done_o), .result_o(result_o), .result_valid_o(result_valid_o),
    .underflow_o(underflow_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      tog <= 1'b0; lc <= 0; age <= 1000;
    end else if (launch_o) begin
      tog <= ~tog; lc <= lc + 1; age <= 1;
    end else if (age < 1000) begin
      age <= age + 1;
    end
  end

  always_comb begin
    if (mode == 2'd0 && code_o == dval) ideal = tog;
    else if (mode == 2'd0)              ideal = (code_o > dval);
    else                                ideal = (code_o >= dval);
    flip = (mode == 2'd2) && ((lc % TRIALS) == 3);
    // a capture taken before the settle time has passed sees the wrong value
    sample_i = (!launch_o && age >= int'(settle_i)) ? (ideal ^ flip) : ~(ideal ^ flip);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    int g = 0;
    while (!done_o && g < 20000) begin
      @(negedge clk); g++;
    end
    ok = done_o;
    if (!ok) check("watchdog R7", 0, 1);
  endtask

  task automatic run_vec(input vec_t v);
    int l0;
    bit ok;
    mode = v.mode; dval = v.d; settle_i = SW'(v.settle);
    @(negedge clk); start_i = 1'b1; l0 = lc;
    @(negedge clk); start_i = 1'b0;
    check("R7 valid cleared by start", result_valid_o, 0);
    while (!launch_o) @(negedge clk);
    check("R2 first trial code", code_o, 512);
    wait_done(ok);
    if (ok) begin
      check("R2/R5/R6 result", result_o, v.res);
      check("R6 underflow", underflow_o, v.uf);
      check("R7 valid at done", result_valid_o, 1);
      check("R9/R4/R3 launch count", lc - l0, int'(v.rounds) * TRIALS);
      @(negedge clk);
      check("R7 done one cycle", done_o, 0);
    end
  endtask

  initial begin
    #150_000_000;
    bad++; checks++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    bit ok;
    int l0, dn;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done in reset", done_o, 0);
    check("R1 valid in reset", result_valid_o, 0);
    check("R1 launch in reset", launch_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 result after reset", result_o, 0);
    check("R1 underflow after reset", underflow_o, 0);
    check("R1 code after reset", code_o, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: start while busy is ignored
    mode = 2'd1; dval = 10'd700; settle_i = 8'd2;
    @(negedge clk); start_i = 1'b1; l0 = lc;
    @(negedge clk); start_i = 1'b0;
    repeat (40) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    dn = 0;
    for (int k = 0; k < 3000; k++) begin
      if (done_o) begin
        dn++;
        if (dn == 1) begin
          check("R8 result unaffected", result_o, 699);
          check("R8 launch count unchanged", lc - l0, 10 * TRIALS);
        end
      end
      @(negedge clk);
    end
    check("R8 single done pulse", dn, 1);
    check("R7 valid held after done", result_valid_o, 1);
    check("R7 result held after done", result_o, 699);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule